// File: doc/BRIEF.md
# Multi-Stream Corner-Turn Selector

The block takes several time-aligned streams of complex samples. The streams share one valid, start and end strobe, and they deliver fixed-length blocks together. Each stream writes its block into a private two-bank buffer. When a block's last word has been stored, the block reads that block back in a new order while the next block fills the other bank.

Each output packet is built as follows. The block walks a list of start offsets. For each offset it visits every input row in ascending order and takes a short run of consecutive columns from that row. Every offset is shifted by a common displacement that grows by a fixed step at the start of each sync interval. The displacement returns to zero before it could push a read past the end of a block. The same packet is driven on every output stream. The first packet of each sync interval carries a sync mark.

A configuration whose offsets still point past the block end sets a sticky error flag.

Top module: `cturn_select`

## Requirements
- R1: While reset is high, and on the cycle after it, every output valid, start, end and sync bit is 0 and the error flag is 0. Reset clears both banks' fill state, the block counter and the displacement.
- R2: Each output packet has exactly OUT_LEN = NOFF × COLS × NIN words on consecutive cycles with valid high. Start is high on word 0 only, end is high on word OUT_LEN-1 only, and valid is low between packets.
- R3: Output word j comes from row (j / COLS) mod NIN, column j mod COLS and offset index j / (COLS × NIN). Offset i is the 16-bit field OFFSETS[16i+15:16i]. The whole word is copied unchanged: imaginary part in the upper DW bits, real part in the lower DW bits.
- R4: The word is read from address offset + column + K in the row's block, where K = COLS × STEP × s and s is the current sync-interval index.
- R5: Blocks are numbered from 0 after reset, and each sync interval holds BPS blocks. Sync is high on word 0 of the first block of each interval and low on every other word.
- R6: When the next interval's largest address (largest offset + COLS − 1 + K) would reach BLK, s returns to 0 instead of incrementing.
- R7: All NOUT output streams carry identical data and flags on every cycle.
- R8: If the end strobe of a block is sampled at clock edge E, output word j appears after edge E + 1 + PIPE_OUT + j.
- R9: Blocks may arrive back to back. A new block is written into the other bank while the previous one is read, and both packets are correct.
- R10: Input cycles with valid low are not written to the buffer and do not advance the write address.
- R11: A read at an address of BLK or more sets the error flag. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word valid, common to all streams |
| inSop | input | 1 | First word of an input block |
| inEop | input | 1 | Last word of an input block |
| inData | input | NIN*2*DW | Input words, stream r at bits [r*2*DW +: 2*DW] |
| outValid | output | NOUT | Output valid per stream |
| outSop | output | NOUT | Output packet start per stream |
| outEop | output | NOUT | Output packet end per stream |
| outSync | output | NOUT | Sync-interval mark per stream |
| outData | output | NOUT*2*DW | Output words, stream o at bits [o*2*DW +: 2*DW] |
| cfgErr | output | 1 | Sticky out-of-range read flag |

## Verification
Output timing is fixed by the edge at which a block's end strobe is sampled. Word j of that block's packet is due exactly 1 + PIPE_OUT + j edges later.

The reference model stamps each expected word with its due edge when it drives the end strobe. It compares every output on the falling edge after each clock. On any cycle that has no word due, the model requires valid to be low.

Back-to-back blocks, blocks with idle gaps inside them, and enough blocks to force the displacement to return to zero are all driven. A second instance has an offset list that reaches past the block end, which exercises the error flag.

// File: rtl/cturn_pkg.sv
package cturn_pkg;
  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
    logic sync;
  } ctFlags_t;
endpackage

// File: rtl/cturn_ctrl.sv
module cturn_ctrl
  import cturn_pkg::*;
#(
  parameter int NIN = 6,
  parameter int BLK = 64,
  parameter int COLS = 2,
  parameter int NOFF = 2,
  parameter logic [NOFF*16-1:0] OFFSETS = {16'd16, 16'd0},
  parameter int STEP = 3,
  parameter int BPS = 4,
  localparam int AW = (BLK > 1) ? $clog2(BLK) : 1,
  localparam int RW = (NIN > 1) ? $clog2(NIN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inSop,
  input  logic          inEop,
  output logic          wrEn,
  output logic          wrBank,
  output logic [AW-1:0] wrAddr,
  output logic          rdBank,
  output logic [AW-1:0] rdAddr,
  output logic [RW-1:0] rdRow,
  output ctFlags_t      flags,
  output logic          cfgErr
);

  function automatic int largestOffset();
    int m = 0;
    for (int i = 0; i < NOFF; i++)
      if (int'(OFFSETS[i*16 +: 16]) > m) m = int'(OFFSETS[i*16 +: 16]);
    return m;
  endfunction

  localparam int MAX_OFF = largestOffset();

  // write side
  int   wrCnt;
  int   wrIdx;
  logic blockDone;

  assign wrIdx     = inSop ? 0 : wrCnt;
  assign wrEn      = inValid;
  assign wrAddr    = AW'(wrIdx);
  assign blockDone = inValid && inEop;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrCnt  <= 0;
      wrBank <= 1'b0;
    end else if (inValid) begin
      if (inEop) begin
        wrCnt  <= 0;
        wrBank <= ~wrBank;
      end else begin
        wrCnt <= wrIdx + 1;
      end
    end
  end

  // read side
  logic running;
  logic curSync;
  int   colCnt, rowCnt, offCnt;
  int   curK, syncIdx, blkCnt;
  int   fullAddr;
  logic lastWord;
  logic firstWord;

  assign lastWord  = running && colCnt == COLS-1 && rowCnt == NIN-1 && offCnt == NOFF-1;
  assign firstWord = running && colCnt == 0 && rowCnt == 0 && offCnt == 0;
  assign fullAddr  = int'(OFFSETS[offCnt*16 +: 16]) + colCnt + curK;
  assign rdAddr    = (fullAddr >= BLK) ? '0 : AW'(fullAddr);
  assign rdRow     = RW'(rowCnt);

  always_comb begin
    flags.valid = running;
    flags.sop   = firstWord;
    flags.eop   = lastWord;
    flags.sync  = firstWord && curSync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      rdBank  <= 1'b0;
      colCnt  <= 0;
      rowCnt  <= 0;
      offCnt  <= 0;
      curK    <= 0;
      curSync <= 1'b0;
      syncIdx <= 0;
      blkCnt  <= 0;
      cfgErr  <= 1'b0;
    end else begin
      if (running && fullAddr >= BLK) cfgErr <= 1'b1;
      if (running) begin
        if (lastWord) running <= 1'b0;
        if (colCnt == COLS-1) begin
          colCnt <= 0;
          if (rowCnt == NIN-1) begin
            rowCnt <= 0;
            offCnt <= offCnt + 1;
          end else begin
            rowCnt <= rowCnt + 1;
          end
        end else begin
          colCnt <= colCnt + 1;
        end
      end
      if (blockDone && (!running || lastWord)) begin
        running <= 1'b1;
        rdBank  <= wrBank;
        colCnt  <= 0;
        rowCnt  <= 0;
        offCnt  <= 0;
        curK    <= COLS * STEP * syncIdx;
        curSync <= (blkCnt == 0);
        if (blkCnt == BPS-1) begin
          blkCnt <= 0;
          if (MAX_OFF + COLS - 1 + COLS * STEP * (syncIdx + 1) >= BLK) syncIdx <= 0;
          else syncIdx <= syncIdx + 1;
        end else begin
          blkCnt <= blkCnt + 1;
        end
      end
    end
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) cfgErr |=> cfgErr);

  // R6
  sync_idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (syncIdx != $past(syncIdx)) |-> (syncIdx == 0 || syncIdx == $past(syncIdx) + 1));

  // R2
  pkt_end_chk: assert property (@(posedge clk) disable iff (rst)
    flags.eop |=> (!flags.valid || flags.sop));

endmodule

// File: rtl/cturn_path.sv
module cturn_path
  import cturn_pkg::*;
#(
  parameter int NIN = 6,
  parameter int NOUT = 2,
  parameter int DW = 16,
  parameter int BLK = 64,
  parameter int PIPE_OUT = 1,
  localparam int WW = 2 * DW,
  localparam int AW = (BLK > 1) ? $clog2(BLK) : 1,
  localparam int RW = (NIN > 1) ? $clog2(NIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NIN*WW-1:0]  inData,
  input  logic               wrEn,
  input  logic               wrBank,
  input  logic [AW-1:0]      wrAddr,
  input  logic               rdBank,
  input  logic [AW-1:0]      rdAddr,
  input  logic [RW-1:0]      rdRow,
  input  ctFlags_t           flags,
  output logic [NOUT-1:0]    outValid,
  output logic [NOUT-1:0]    outSop,
  output logic [NOUT-1:0]    outEop,
  output logic [NOUT-1:0]    outSync,
  output logic [NOUT*WW-1:0] outData
);

  int wrIdx, rdIdx;
  assign wrIdx = (wrBank ? BLK : 0) + int'(wrAddr);
  assign rdIdx = (rdBank ? BLK : 0) + int'(rdAddr);

  logic [NIN*WW-1:0] rowBus;

  for (genvar r = 0; r < NIN; r++) begin : g_row
    logic [WW-1:0] mem [2*BLK];
    logic [WW-1:0] rowQ;
    always_ff @(posedge clk) begin
      if (wrEn) mem[wrIdx] <= inData[r*WW +: WW];
      rowQ <= mem[rdIdx];
    end
    assign rowBus[r*WW +: WW] = rowQ;
  end

  logic [RW-1:0] rowSelQ;
  ctFlags_t      flagsQ;
  logic [WW-1:0] selWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      flagsQ  <= '0;
      rowSelQ <= '0;
    end else begin
      flagsQ  <= flags;
      rowSelQ <= rdRow;
    end
  end

  assign selWord = rowBus[int'(rowSelQ)*WW +: WW];

  ctFlags_t      finFlags;
  logic [WW-1:0] finWord;

  if (PIPE_OUT > 0) begin : g_pipe
    always_ff @(posedge clk) begin
      if (rst) begin
        finFlags <= '0;
        finWord  <= '0;
      end else begin
        finFlags <= flagsQ;
        finWord  <= selWord;
      end
    end
  end else begin : g_nopipe
    assign finFlags = flagsQ;
    assign finWord  = selWord;
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    assign outValid[o]          = finFlags.valid;
    assign outSop[o]            = finFlags.sop;
    assign outEop[o]            = finFlags.eop;
    assign outSync[o]           = finFlags.sync;
    assign outData[o*WW +: WW]  = finWord;
  end

  // R2
  pkt_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid[0] && !outEop[0]) |=> outValid[0]);

  // R5
  sync_on_sop_chk: assert property (@(posedge clk) disable iff (rst)
    outSync[0] |-> (outSop[0] && outValid[0]));

  // R2
  sop_follows_eop_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid[0] && outEop[0]) |=> (!outValid[0] || outSop[0]));

endmodule

// File: rtl/cturn_select.sv
module cturn_select
  import cturn_pkg::*;
#(
  parameter int NIN = 6,
  parameter int NOUT = 2,
  parameter int DW = 16,
  parameter int BLK = 64,
  parameter int COLS = 2,
  parameter int NOFF = 2,
  parameter logic [NOFF*16-1:0] OFFSETS = {16'd16, 16'd0},
  parameter int STEP = 3,
  parameter int BPS = 4,
  parameter int PIPE_OUT = 1,
  localparam int WW = 2 * DW,
  localparam int AW = (BLK > 1) ? $clog2(BLK) : 1,
  localparam int RW = (NIN > 1) ? $clog2(NIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [NIN*WW-1:0]  inData,
  output logic [NOUT-1:0]    outValid,
  output logic [NOUT-1:0]    outSop,
  output logic [NOUT-1:0]    outEop,
  output logic [NOUT-1:0]    outSync,
  output logic [NOUT*WW-1:0] outData,
  output logic               cfgErr
);

  logic          wrEn, wrBank, rdBank;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [RW-1:0] rdRow;
  ctFlags_t      flags;

  cturn_ctrl #(
    .NIN(NIN), .BLK(BLK), .COLS(COLS), .NOFF(NOFF), .OFFSETS(OFFSETS),
    .STEP(STEP), .BPS(BPS)
  ) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .wrEn(wrEn), .wrBank(wrBank), .wrAddr(wrAddr),
    .rdBank(rdBank), .rdAddr(rdAddr), .rdRow(rdRow),
    .flags(flags), .cfgErr(cfgErr)
  );

  cturn_path #(
    .NIN(NIN), .NOUT(NOUT), .DW(DW), .BLK(BLK), .PIPE_OUT(PIPE_OUT)
  ) i_path (
    .clk(clk), .rst(rst), .inData(inData),
    .wrEn(wrEn), .wrBank(wrBank), .wrAddr(wrAddr),
    .rdBank(rdBank), .rdAddr(rdAddr), .rdRow(rdRow), .flags(flags),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outSync(outSync), .outData(outData)
  );

endmodule

// File: tb/test_cturn_select.sv
module test_cturn_select;
  localparam int NIN = 6, NOUT = 2, DW = 16, BLK = 64, COLS = 2, NOFF = 2;
  localparam int STEP = 3, BPS = 4, PIPE_OUT = 1, WW = 2 * DW;
  localparam int OUT_LEN = NOFF * COLS * NIN;
  localparam int OFF0 = 0, OFF1 = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [NIN*WW-1:0] inData = '0;
  logic [NOUT-1:0] outValid, outSop, outEop, outSync;
  logic [NOUT*WW-1:0] outData;
  logic cfgErr;
  logic [NOUT-1:0] bValid, bSop, bEop, bSync;
  logic [NOUT*WW-1:0] bData;
  logic badErr;

  always #4 clk = ~clk;

  cturn_select #(.NIN(NIN), .NOUT(NOUT), .DW(DW), .BLK(BLK), .COLS(COLS), .NOFF(NOFF),
    .OFFSETS({16'd16, 16'd0}), .STEP(STEP), .BPS(BPS), .PIPE_OUT(PIPE_OUT)) i_cturn_select (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop), .inData(inData),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outSync(outSync),
    .outData(outData), .cfgErr(cfgErr));

  cturn_select #(.NIN(NIN), .NOUT(NOUT), .DW(DW), .BLK(BLK), .COLS(COLS), .NOFF(NOFF),
    .OFFSETS({16'd63, 16'd0}), .STEP(STEP), .BPS(BPS), .PIPE_OUT(0)) i_cturn_bad (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop), .inData(inData),
    .outValid(bValid), .outSop(bSop), .outEop(bEop), .outSync(bSync),
    .outData(bData), .cfgErr(badErr));

  typedef struct {
    int          due;
    logic [WW-1:0] word;
    bit          sop, eop, sync;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [WW-1:0] blkMem [NIN][BLK];
  int checks = 0, failures = 0, cyc = 0, nWrap = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compareOut();
    if (q.size() > 0 && q[0].due == cyc) begin
      for (int o = 0; o < NOUT; o++) begin
        chk(outValid[o] == 1'b1, {"R2 valid ", q[0].tag}, 64'(outValid[o]), 64'd1);
        chk(outSop[o] == q[0].sop && outEop[o] == q[0].eop, {"R2 R8 sop/eop ", q[0].tag},
            64'({outSop[o], outEop[o]}), 64'({q[0].sop, q[0].eop}));
        chk(outSync[o] == q[0].sync, {"R5 sync ", q[0].tag}, 64'(outSync[o]), 64'(q[0].sync));
        chk(outData[o*WW +: WW] == q[0].word, {"R3 R4 R7 data ", q[0].tag},
            64'(outData[o*WW +: WW]), 64'(q[0].word));
      end
      void'(q.pop_front());
    end else begin
      chk(outValid == '0, "R2 idle valid", 64'(outValid), 64'd0);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    compareOut();
  endtask

  task automatic pushExpected(input int b, input int eEdge, input string mtag);
    int s = (b / BPS) % nWrap;
    int k = COLS * s * STEP;
    for (int j = 0; j < OUT_LEN; j++) begin
      exp_t e;
      int oi  = j / (COLS * NIN);
      int row = (j / COLS) % NIN;
      int col = j % COLS;
      int adr = ((oi == 0) ? OFF0 : OFF1) + col + k;
      e.due  = eEdge + 1 + PIPE_OUT + j;
      e.word = blkMem[row][adr];
      e.sop  = (j == 0);
      e.eop  = (j == OUT_LEN - 1);
      e.sync = (j == 0) && (b % BPS == 0);
      e.tag  = (s == 0 && b >= BPS) ? {mtag, " R6 wrapped"} : mtag;
      q.push_back(e);
    end
  endtask

  // mode 0: back to back (R9), mode 1: idle cycles inside block (R10)
  task automatic sendBlock(input int b, input int mode);
    int w = 0;
    int i = 0;
    while (w < BLK) begin
      if (mode == 1 && (i % 5) == 3) begin
        inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
        inData = {NIN{32'hDEAD_BEEF}};
        tick();
      end else begin
        inValid = 1'b1;
        inSop = (w == 0);
        inEop = (w == BLK - 1);
        for (int r = 0; r < NIN; r++) begin
          logic [DW-1:0] re = DW'(b * 41 + w * 3 + r * 97);
          logic [DW-1:0] im = re ^ 16'h5A5A;
          blkMem[r][w] = {im, re};
          inData[r*WW +: WW] = {im, re};
        end
        if (w == BLK - 1) pushExpected(b, cyc + 1, (mode == 1) ? "R10 gapped" : "R9 back-to-back");
        w++;
        tick();
      end
      i++;
    end
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  initial begin
    while (OFF1 + COLS - 1 + COLS * STEP * nWrap < BLK) nWrap++;
    repeat (4) begin
      tick();
      chk(outValid == '0 && outSop == '0 && outEop == '0 && outSync == '0, "R1 reset flags",
          64'({outValid, outSop, outEop, outSync}), 64'd0);
      chk(cfgErr == 1'b0 && badErr == 1'b0, "R1 reset err", 64'({cfgErr, badErr}), 64'd0);
    end
    rst = 1'b0;
    tick();
    chk(cfgErr == 1'b0 && badErr == 1'b0, "R1 after reset err", 64'({cfgErr, badErr}), 64'd0);
    for (int b = 0; b < nWrap * BPS + 6; b++) begin
      sendBlock(b, (b % 3 == 1) ? 1 : 0);
      if (b % 3 == 2) repeat (10) tick();
    end
    repeat (OUT_LEN + 6) tick();
    chk(q.size() == 0, "R2 all words seen", 64'(q.size()), 64'd0);
    chk(cfgErr == 1'b0, "R11 good config no error", 64'(cfgErr), 64'd0);
    chk(badErr == 1'b1, "R11 bad config sticky error", 64'(badErr), 64'd1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule